// File: doc/BRIEF.md
# Status-Decoding Bus Cycle Controller

This block sits next to a processor whose bus cycles are announced by a three-bit, active-low status code rather than by discrete read and write pins. It watches the code. When the code leaves its passive value, the block walks the cycle through four clock states: address (T1), command start (T2), command hold (T3) and finish (T4). Wait states are inserted after T3 for as long as the synchronised ready line stays low.

From the latched cycle type, the block rebuilds five separate command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces a one-state address latch enable pulse for the external address latches. For the external data transceivers it produces an enable and a direction signal.

All outputs are active-high and registered. Each output changes on the clock edge that moves the sequencer into the state the output belongs to.

Top module: `bus_cycle_ctl`

## Requirements
- R1: Synchronous active-high reset, including during a cycle, drives every output low on the next edge and returns the sequencer to idle.
- R2: A cycle starts on the first edge where `stat_n` is not 3'b111 and the previous sampled code was 3'b111. `ale` is high for exactly the one following state (T1). T1, T2 and T3 follow on consecutive edges.
- R3: The status code, written as `stat_n[2:0]`, selects the cycle type: 3'b101 memory read, 3'b001 I/O read, 3'b110 memory write, 3'b010 I/O write, 3'b000 interrupt acknowledge. 3'b111 is passive.
- R4: The selected command strobe is high in T2, T3 and every wait state, and low from T4 on. At most one command strobe is ever high.
- R5: `rdy` is sampled on the edge that ends T3 and on the edge that ends each wait state. Low inserts (or extends) a wait state; high moves to T4. T4 always returns to idle on the next edge.
- R6: `xcvr_en` is high from T2 through T3 and wait states for read and acknowledge cycles. For write cycles it is high from T2 through T4.
- R7: `dir_tx` is 1 (transmit) in every state T1 to T4 of a write cycle and 0 otherwise.
- R8: Codes 3'b011 and 3'b100 run a full cycle with `ale` and wait states, but raise no command strobe and no `xcvr_en`, and leave `dir_tx` at 0.
- R9: A status code held non-passive past the end of a cycle starts no new cycle until the code has returned to 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_n | input | 3 | Active-low cycle status code |
| rdy | input | 1 | Synchronised ready; low requests wait states |
| ale | output | 1 | Address latch enable pulse (T1) |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |
| xcvr_en | output | 1 | Data transceiver enable |
| dir_tx | output | 1 | Transceiver direction, 1 = transmit |

## Verification
A wrong phase register shows at the ports within one state. It appears as an `ale` pulse of the wrong length, a command that starts or drops a state early or late, or a wait state that is taken or skipped against `rdy`.

A wrong latched cycle type shows in T2 as a different strobe or a wrong direction. This matters most when status has already gone passive in T2, because the type can then only come from the latch.

A stale passive-tracking flag shows as a spurious `ale` one state after a cycle ends while status is held.

The bench compares all eight outputs in every state of every cycle. It therefore catches each of these faults in the first state in which it is visible.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] CODE_IDLE = {STAT_W{1'b1}};

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4
  } phase_e;

  typedef enum logic [2:0] {
    CY_NONE, CY_IORD, CY_IOWR, CY_MRD, CY_MWR, CY_ACK
  } cyc_e;
endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
(
  input  logic [STAT_W-1:0] stat_n,
  output cyc_e              kind,
  output logic              passive
);
  always_comb begin
    case (stat_n)
      3'b000:  kind = CY_ACK;
      3'b001:  kind = CY_IORD;
      3'b010:  kind = CY_IOWR;
      3'b101:  kind = CY_MRD;
      3'b110:  kind = CY_MWR;
      default: kind = CY_NONE;
    endcase
  end

  assign passive = (stat_n == CODE_IDLE);
endmodule

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   passive,
  input  cyc_e   kind,
  input  logic   rdy,
  output phase_e ph_d,
  output cyc_e   kind_d
);
  phase_e ph_q;
  cyc_e   kind_q;
  logic   prev_pass;
  logic   start;

  assign start = (ph_q == PH_IDLE) && !passive && prev_pass;

  always_comb begin
    ph_d   = ph_q;
    kind_d = kind_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_d   = PH_T1;
        kind_d = kind;
      end
      PH_T1:          ph_d = PH_T2;
      PH_T2:          ph_d = PH_T3;
      PH_T3, PH_TW:   ph_d = rdy ? PH_T4 : PH_TW;
      PH_T4:          ph_d = PH_IDLE;
      default:        ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      kind_q    <= CY_NONE;
      prev_pass <= 1'b1;
    end else begin
      ph_q      <= ph_d;
      kind_q    <= kind_d;
      prev_pass <= passive;
    end
  end

  // R5: a low ready at the end of T3 or Tw yields a wait state
  assert_wait_insert_R5: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_T3 || ph_q == PH_TW) && !rdy) |=> (ph_q == PH_TW));
  assert_wait_exit_R5: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_T3 || ph_q == PH_TW) && rdy) |=> (ph_q == PH_T4));
  assert_t4_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_T4) |=> (ph_q == PH_IDLE));
  // R9: no start while the previous code was non-passive
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE && !prev_pass) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e ph_d,
  input  cyc_e   kind_d,
  output logic   ale,
  output logic   mem_rd,
  output logic   mem_wr,
  output logic   io_rd,
  output logic   io_wr,
  output logic   int_ack,
  output logic   xcvr_en,
  output logic   dir_tx
);
  logic in_cmd, in_data, is_wr, is_rx;

  assign in_cmd  = (ph_d == PH_T2) || (ph_d == PH_T3) || (ph_d == PH_TW);
  assign in_data = in_cmd || (ph_d == PH_T4);
  assign is_wr   = (kind_d == CY_MWR) || (kind_d == CY_IOWR);
  assign is_rx   = (kind_d == CY_MRD) || (kind_d == CY_IORD) || (kind_d == CY_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      io_rd   <= 1'b0;
      io_wr   <= 1'b0;
      int_ack <= 1'b0;
      xcvr_en <= 1'b0;
      dir_tx  <= 1'b0;
    end else begin
      ale     <= (ph_d == PH_T1);
      mem_rd  <= in_cmd && (kind_d == CY_MRD);
      mem_wr  <= in_cmd && (kind_d == CY_MWR);
      io_rd   <= in_cmd && (kind_d == CY_IORD);
      io_wr   <= in_cmd && (kind_d == CY_IOWR);
      int_ack <= in_cmd && (kind_d == CY_ACK);
      xcvr_en <= (in_cmd && is_rx) || (in_data && is_wr);
      dir_tx  <= is_wr && (ph_d != PH_IDLE);
    end
  end

  // R4: never more than one command strobe
  assert_one_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr, int_ack}));
  // R2: address latch enable lasts one state and never overlaps a command
  assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  assert_ale_no_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    ale |-> !(mem_rd || mem_wr || io_rd || io_wr || int_ack || xcvr_en));
  // R6: writes keep the transceiver on after the command drops, reads do not
  assert_wr_en_t4_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr || io_wr) |-> xcvr_en);
  assert_rd_en_off_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_rd || io_rd || int_ack) |-> !xcvr_en);
  // R7: direction turns to transmit only at T1 and back only when the cycle is over
  assert_dir_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dir_tx) |-> ale);
  assert_dir_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(dir_tx) |-> !(xcvr_en || mem_wr || io_wr));
endmodule

// File: rtl/bus_cycle_ctl.sv
module bus_cycle_ctl
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_n,
  input  logic              rdy,
  output logic              ale,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              int_ack,
  output logic              xcvr_en,
  output logic              dir_tx
);
  cyc_e   kind_now, kind_nxt;
  logic   passive;
  phase_e ph_nxt;

  bcs_decode u_dec (
    .stat_n  (stat_n),
    .kind    (kind_now),
    .passive (passive)
  );

  bcs_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .passive (passive),
    .kind    (kind_now),
    .rdy     (rdy),
    .ph_d    (ph_nxt),
    .kind_d  (kind_nxt)
  );

  bcs_drive u_drv (
    .clk     (clk),
    .rst     (rst),
    .ph_d    (ph_nxt),
    .kind_d  (kind_nxt),
    .ale     (ale),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .int_ack (int_ack),
    .xcvr_en (xcvr_en),
    .dir_tx  (dir_tx)
  );

  // R1: reset leaves every output low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !(ale || mem_rd || mem_wr || io_rd || io_wr || int_ack || xcvr_en || dir_tx));
endmodule

// File: tb/sim_bus_cycle_ctl.sv
module sim_bus_cycle_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] stat_n = 3'b111;
  logic rdy = 1'b1;
  logic ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, xcvr_en, dir_tx;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  bus_cycle_ctl u0 (
    .clk(clk), .rst(rst), .stat_n(stat_n), .rdy(rdy),
    .ale(ale), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .int_ack(int_ack), .xcvr_en(xcvr_en), .dir_tx(dir_tx)
  );

  function automatic logic [7:0] outs();
    return {ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, xcvr_en, dir_tx};
  endfunction

  // phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 Tw
  function automatic logic [7:0] expect_vec(logic [2:0] code, int phase);
    logic wr, rx, cmd, dat;
    wr  = (code == 3'b110) || (code == 3'b010);
    rx  = (code == 3'b101) || (code == 3'b001) || (code == 3'b000);
    cmd = (phase == 2) || (phase == 3) || (phase == 5);
    dat = cmd || (phase == 4);
    return {phase == 1,
            cmd && code == 3'b101, cmd && code == 3'b110,
            cmd && code == 3'b001, cmd && code == 3'b010,
            cmd && code == 3'b000,
            (cmd && rx) || (dat && wr),
            wr && phase != 0};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic push(logic [7:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: one expected vector per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), outs(), exp_q.pop_front());
    end
  end

  task automatic idle_steps(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push(8'h00, tag);
    end
  endtask

  task automatic bus_cycle(logic [2:0] code, int waits, bit hold, string tag);
    @(negedge clk); stat_n = code; rdy = 1'b1;
    push(expect_vec(code, 1), {tag, " T1"});
    @(negedge clk); if (!hold) stat_n = 3'b111;
    push(expect_vec(code, 2), {tag, " T2"});
    @(negedge clk);
    push(expect_vec(code, 3), {tag, " T3"});
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk); rdy = (k == waits);
      push(expect_vec(code, (k == waits) ? 4 : 5), {tag, (k == waits) ? " T4" : " Tw"});
    end
    @(negedge clk); rdy = 1'b1;
    push(8'h00, {tag, " idle"});
  endtask

  initial begin
    #(20000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), 8'h00);
    @(negedge clk); rst = 1'b0;
    idle_steps(2, "R1 passive bus stays idle");
    bus_cycle(3'b101, 0, 0, "R3 mem read");
    bus_cycle(3'b001, 1, 0, "R3 R5 io read one wait");
    bus_cycle(3'b110, 0, 0, "R6 mem write");
    bus_cycle(3'b010, 2, 0, "R7 io write two waits");
    bus_cycle(3'b000, 0, 0, "R3 int ack");
    bus_cycle(3'b011, 1, 0, "R8 code 011");
    bus_cycle(3'b100, 0, 0, "R8 code 100");
    bus_cycle(3'b101, 0, 1, "R9 held status");
    idle_steps(3, "R9 held status no restart");
    @(negedge clk); stat_n = 3'b111; push(8'h00, "R9 back to passive");
    bus_cycle(3'b110, 0, 0, "R2 back to back first");
    bus_cycle(3'b001, 0, 0, "R2 back to back second");
    idle_steps(1, "R2 idle");
    wait (exp_q.size() == 0);
    // reset in the middle of a cycle
    @(negedge clk); stat_n = 3'b101;
    @(negedge clk); stat_n = 3'b111;
    @(negedge clk);
    check("R2 T2 reached before reset", outs(), expect_vec(3'b101, 2));
    rst = 1'b1;
    @(posedge clk); #2;
    check("R1 mid-cycle reset", outs(), 8'h00);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    check("R1 idle after reset", outs(), 8'h00);
    bus_cycle(3'b110, 1, 0, "R1 recovery write");
    idle_steps(1, "R1 recovery idle");
    wait (exp_q.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule